// File: doc/BRIEF.md
# DMA request generator channel

This block is one channel of a DMA request generator. It watches one line picked out of a vector of trigger inputs. When that line shows the chosen kind of edge, the channel issues a burst of DMA requests. The burst holds `req_count + 1` requests. Each request stays asserted until the DMA controller acknowledges it as served. After the last request has been served, the channel goes quiet until the next trigger.

If a new trigger arrives while a burst is still in progress, the channel sets a sticky overrun flag. It then reloads its counter and starts the burst again. Software clears the flag with a one-cycle pulse.

The configuration fields arrive as plain input ports: trigger select, edge mode, enable and request count. The request count must only change while the channel is disabled. Dropping the enable aborts any burst in progress.

Top module: `dma_reqgen_chan`

## Requirements
- R1: After reset, `dma_req` and `ovr_flag` are 0, and the stored previous value of the selected trigger is 0.
- R2: Only `trig_in[trig_sel]` can start a burst. Activity on any other trigger line has no effect on `dma_req`.
- R3: `edge_mode` is decoded as follows: 2'b00 never fires, 2'b01 fires on a rise (previous 0, now 1), 2'b10 fires on a fall, and 2'b11 fires on either. "Previous" means the selected input as it was sampled at the prior clock edge.
- R4: While `enable` is 0, no trigger is acted on. Clearing `enable` drops `dma_req` at the next edge and aborts the burst.
- R5: A trigger event while enabled loads the counter from `req_count` and drives `dma_req` to 1 at that same clock edge.
- R6: `dma_req` stays 1 until `served` is sampled high with it. It then reads 0 for exactly one cycle and returns to 1 if requests remain in the burst.
- R7: Each trigger yields exactly `req_count + 1` served requests. After the last one is served, `dma_req` stays 0 until the next trigger.
- R8: A `served` pulse sampled while `dma_req` is 0 is ignored and does not shorten the burst.
- R9: A trigger event while enabled and while a burst is still in progress sets `ovr_flag`, reloads the counter and restarts the burst.
- R10: `ovr_flag` stays set until an `ovr_clear` pulse. If a new overrun occurs in the same cycle as the clear, the flag stays set.
- R11: When a trigger and `served` arrive in the same cycle, the trigger wins: `dma_req` stays 1 and the counter is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel enable |
| trig_in | input | 32 | Trigger input vector |
| trig_sel | input | 5 | Index of the trigger input to watch |
| edge_mode | input | 2 | Active edge: 00 none, 01 rise, 10 fall, 11 both |
| req_count | input | 5 | Requests per burst minus one |
| served | input | 1 | DMA acknowledge that the current request was served |
| ovr_clear | input | 1 | One-cycle clear of the overrun flag |
| dma_req | output | 1 | DMA request line |
| ovr_flag | output | 1 | Sticky trigger overrun flag |

## Verification
Two collisions matter for this block.

The first is a trigger landing on the same edge as a `served` acknowledge. The bench provokes it by pulsing the selected trigger while a request is being served. It judges the result by `dma_req` staying high and a full burst following.

The second is an overrun set landing in the same cycle as `ovr_clear`. The bench lines up a mid-burst trigger with the clear pulse and expects `ovr_flag` to stay set.

Random cycles mix both collisions freely, and a cycle model in the bench checks every one of them.

// File: rtl/dma_reqgen_pkg.sv
package dma_reqgen_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // True when the selected line moved in the direction the mode asks for.
  function automatic logic edge_hit(input logic [1:0] mode, input logic prev, input logic cur);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    case (mode)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma_reqgen_trig.sv
module dma_reqgen_trig #(
  parameter int SEL_W = 5,
  localparam int N_TRIG = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [1:0]        edge_mode,
  output logic              hit
);
  import dma_reqgen_pkg::*;

  logic sel_now;
  logic sel_prev_q;

  assign sel_now = trig_in[trig_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev_q <= 1'b0;
    else        sel_prev_q <= sel_now;
  end

  assign hit = edge_hit(edge_mode, sel_prev_q, sel_now);

endmodule

// File: rtl/dma_reqgen_burst.sv
module dma_reqgen_burst #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trig_evt,
  input  logic             served,
  input  logic [CNT_W-1:0] req_count,
  output logic             dma_req,
  output logic             burst_active
);

  logic             req_q;
  logic             act_q;
  logic [CNT_W-1:0] rem_q;
  logic             handshake;
  logic             last_one;

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] v);
    count_down = v - CNT_W'(1);
  endfunction

  assign handshake = req_q & served;
  assign last_one  = (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (!enable) begin
      req_q <= 1'b0;
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (trig_evt) begin
      req_q <= 1'b1;
      act_q <= 1'b1;
      rem_q <= req_count;
    end else if (act_q) begin
      if (handshake) begin
        req_q <= 1'b0;
        if (last_one) act_q <= 1'b0;
        else          rem_q <= count_down(rem_q);
      end else if (!req_q) begin
        req_q <= 1'b1;
      end
    end
  end

  assign dma_req      = req_q;
  assign burst_active = act_q;

endmodule

// File: rtl/dma_reqgen_ovr.sv
module dma_reqgen_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  assign flag = flag_q;

endmodule

// File: rtl/dma_reqgen_chan.sv
module dma_reqgen_chan #(
  parameter int SEL_W = 5,
  parameter int CNT_W = 5,
  localparam int N_TRIG = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [1:0]        edge_mode,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              served,
  input  logic              ovr_clear,
  output logic              dma_req,
  output logic              ovr_flag
);

  logic edge_seen;
  logic trig_evt;
  logic burst_active;
  logic ovr_evt;

  dma_reqgen_trig #(.SEL_W(SEL_W)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig_in),
    .trig_sel  (trig_sel),
    .edge_mode (edge_mode),
    .hit       (edge_seen)
  );

  assign trig_evt = enable & edge_seen;
  assign ovr_evt  = trig_evt & burst_active;

  dma_reqgen_burst #(.CNT_W(CNT_W)) u_burst (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .trig_evt     (trig_evt),
    .served       (served),
    .req_count    (req_count),
    .dma_req      (dma_req),
    .burst_active (burst_active)
  );

  dma_reqgen_ovr u_ovr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (ovr_evt),
    .clr     (ovr_clear),
    .flag    (ovr_flag)
  );

endmodule

// File: rtl/dma_reqgen_chan_chk.sv
module dma_reqgen_chan_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic served,
  input logic ovr_clear,
  input logic dma_req,
  input logic ovr_flag,
  input logic trig_evt,
  input logic burst_active
);

  p_disable_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !dma_req);

  p_trig_asserts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> dma_req);

  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !served && enable && !trig_evt) |=> dma_req);

  p_served_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && served && !trig_evt) |=> !dma_req);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_active && !trig_evt) |=> !dma_req);

  p_overrun_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && burst_active) |=> ovr_flag);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clear) |=> ovr_flag);

  p_flag_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clear && !(trig_evt && burst_active)) |=> !ovr_flag);

endmodule

bind dma_reqgen_chan dma_reqgen_chan_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .served       (served),
  .ovr_clear    (ovr_clear),
  .dma_req      (dma_req),
  .ovr_flag     (ovr_flag),
  .trig_evt     (trig_evt),
  .burst_active (burst_active)
);

// File: tb/dma_reqgen_chan_test.sv
module dma_reqgen_chan_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] trig_in = '0;
  logic [4:0]  trig_sel = '0;
  logic [1:0]  edge_mode = '0;
  logic [4:0]  req_count = '0;
  logic        served = 1'b0;
  logic        ovr_clear = 1'b0;
  logic        dma_req;
  logic        ovr_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  bit m_prev, m_act, m_req, m_ovr;
  int m_rem;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_reqgen_chan uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trig_in(trig_in),
    .trig_sel(trig_sel), .edge_mode(edge_mode), .req_count(req_count),
    .served(served), .ovr_clear(ovr_clear), .dma_req(dma_req), .ovr_flag(ovr_flag)
  );

  function automatic bit fires(logic [1:0] m, bit p, bit c);
    return (m[0] && !p && c) || (m[1] && p && !c);
  endfunction

  task automatic expect_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Advance the model with the inputs now on the pins, clock once, compare.
  task automatic tick();
    bit cur, e;
    cur = trig_in[trig_sel];
    e = enable && fires(edge_mode, m_prev, cur);
    m_prev = cur;
    if (e && m_act) m_ovr = 1;
    else if (ovr_clear) m_ovr = 0;
    if (!enable) begin
      m_act = 0; m_req = 0; m_rem = 0;
    end else if (e) begin
      m_act = 1; m_req = 1; m_rem = req_count;
    end else if (m_act) begin
      if (m_req && served) begin
        m_req = 0;
        if (m_rem == 0) m_act = 0;
        else m_rem--;
      end else if (!m_req) m_req = 1;
    end
    @(posedge clk);
    @(negedge clk);
    expect_bit(tag, "dma_req", dma_req, m_req);
    expect_bit(tag, "ovr_flag", ovr_flag, m_ovr);
  endtask

  task automatic idle_inputs();
    served = 0; ovr_clear = 0;
  endtask

  initial begin
    #(CLK_PERIOD*190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int served_cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    expect_bit("R1", "dma_req after reset", dma_req, 1'b0);
    expect_bit("R1", "ovr_flag after reset", ovr_flag, 1'b0);
    rst_n = 1;
    m_prev = 0; m_act = 0; m_req = 0; m_ovr = 0; m_rem = 0;
    tick();

    // R2: other lines toggle, selected line quiet
    tag = "R2";
    enable = 1; edge_mode = 2'b11; trig_sel = 5'd7; req_count = 5'd1;
    for (int i = 0; i < 6; i++) begin
      trig_in = (i % 2) ? 32'hFFFF_FF7F : 32'h0;
      tick();
    end
    expect_bit("R2", "no request from unselected lines", dma_req, 1'b0);
    trig_in = 0; tick();

    // R8: served while idle ignored, R5/R6/R7 burst of 4 with rising edge
    tag = "R8";
    enable = 0; tick();
    req_count = 5'd3; edge_mode = 2'b01; trig_sel = 5'd5; enable = 1;
    served = 1; tick(); tick();
    expect_bit("R8", "idle served leaves request low", dma_req, 1'b0);
    served = 0;
    tag = "R5";
    trig_in[5] = 1; tick();
    expect_bit("R5", "request after rising edge", dma_req, 1'b1);
    tag = "R6";
    tick(); tick();
    expect_bit("R6", "request held while unserved", dma_req, 1'b1);
    tag = "R7";
    served_cnt = 0;
    for (int i = 0; i < 30; i++) begin
      served = dma_req;
      if (dma_req) served_cnt++;
      tick();
    end
    served = 0;
    expect_bit("R7", "served count equals count+1", served_cnt == 4, 1'b1);
    expect_bit("R7", "quiet after burst", dma_req, 1'b0);

    // R3: falling edge mode, and mode 00 never fires
    tag = "R3";
    enable = 0; tick();
    edge_mode = 2'b00; req_count = 5'd0; enable = 1;
    trig_in[5] = 0; tick(); trig_in[5] = 1; tick();
    expect_bit("R3", "mode 00 no request", dma_req, 1'b0);
    edge_mode = 2'b10; trig_in[5] = 0; tick();
    expect_bit("R3", "falling edge request", dma_req, 1'b1);
    served = 1; tick(); served = 0; tick();
    expect_bit("R3", "single request done", dma_req, 1'b0);

    // R11 and R9: trigger with served in same cycle, overrun set
    tag = "R11";
    edge_mode = 2'b11;
    trig_in[5] = 1; tick();
    served = 1; trig_in[5] = 0; tick();
    served = 0;
    expect_bit("R11", "trigger beats served", dma_req, 1'b1);
    expect_bit("R9", "overrun on mid-burst trigger", ovr_flag, 1'b1);

    // R10: clear alone clears; clear with overrun keeps flag
    tag = "R10";
    ovr_clear = 1; tick(); ovr_clear = 0;
    expect_bit("R10", "clear drops flag", ovr_flag, 1'b0);
    tick();
    ovr_clear = 1; trig_in[5] = 1; tick(); ovr_clear = 0;
    expect_bit("R10", "set wins over clear", ovr_flag, 1'b1);
    tick();
    expect_bit("R10", "flag sticky", ovr_flag, 1'b1);

    // R4: disable aborts, trigger while disabled ignored
    tag = "R4";
    enable = 0; tick();
    expect_bit("R4", "disable drops request", dma_req, 1'b0);
    trig_in[5] = 0; tick(); trig_in[5] = 1; tick();
    expect_bit("R4", "no request while disabled", dma_req, 1'b0);
    ovr_clear = 1; tick(); idle_inputs();

    // random phase
    tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(99);
      if (r < 3) begin
        enable = 0; req_count = 5'($urandom_range(4));
      end else enable = 1;
      trig_sel = ($urandom_range(3) == 0) ? 5'd31 : 5'($urandom_range(3));
      trig_in = ($urandom_range(9) < 2) ? $urandom : trig_in;
      edge_mode = ($urandom_range(19) == 0) ? 2'($urandom_range(3)) : edge_mode;
      served = ($urandom_range(9) < 4);
      ovr_clear = ($urandom_range(19) == 0);
      tick();
    end
    idle_inputs();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end

endmodule